// File: doc/BRIEF.md
# Descriptor Ring Completion Engine

This block runs one channel of a circular descriptor ring. Software fills descriptors in a small internal descriptor store and sets the ring size. It then publishes work by moving a head index forward. The engine walks the ring from its own tail index up to the head, one descriptor at a time. It hands each descriptor to a fixed-latency transfer stub that stands in for the data path. When the transfer finishes, the engine writes the completion back into that descriptor's flag field and advances the tail. Software owns the head and the engine alone owns the tail.

Each descriptor is a 128-bit word. A per-descriptor bit asks for a one-cycle completion pulse, which feeds a separate notification block. A descriptor that reaches the engine without its posted mark is treated as a protocol error: the ring halts until software clears the error. With `IS_RX` set, the ring works as a receive ring, and completion also writes the received length and the frame-boundary fields into the descriptor.

Top module: `ring_walker`

## Requirements
- R1: After reset, the flags, count, head and tail registers all read zero, and `err_halt`, `cmpl_pulse`, `ring_busy` and `xfer_start` are low.
- R2: The descriptor word layout is: bits [63:0] buffer address, [75:64] length, [79:76] end-of-frame, [83:80] start-of-frame, [95:84] flags and [127:96] time word. Descriptor flag bit 0 is isochronous, bit 1 is completed, bit 2 is posted and bit 3 is interrupt request. On completion the engine sets flag bit 1. It leaves the address, the time word and every other flag bit unchanged.
- R3: Descriptors are processed strictly in ring order, starting at the tail. Exactly one `xfer_start` is issued per descriptor, carrying that descriptor's address. The tail advances by one per completion and stops when it equals the head.
- R4: The count register (address 1) sets the ring size, and the tail wraps to 0 when it reaches the count. A count write larger than `DEPTH` stores `DEPTH`. Any count write resets the tail to 0.
- R5: Work starts only while bit 31 of the ring flags word (address 0) is set. Clearing it lets the descriptor already in flight complete, and no further descriptor is started.
- R6: `cmpl_pulse` is high for exactly one cycle for each completed descriptor whose flag bit 3 is set. It stays low for completions with bit 3 clear.
- R7: If the descriptor at the tail has flag bit 2 clear, the engine raises `err_halt`, starts nothing, leaves the tail and that descriptor unchanged, and stays halted. Writing the flags word with bit 31 clear drops `err_halt`.
- R8: On a receive ring, completion writes the values on `rx_len`, `rx_eof` and `rx_sof` into the descriptor's length, end-of-frame and start-of-frame fields.
- R9: The tail register (address 3) is read-only, and software writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 flags, 1 count, 2 head, 3 tail |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| desc_we | input | 1 | Descriptor store write strobe |
| desc_idx | input | IDX_W | Descriptor slot for software write and read |
| desc_wdata | input | 128 | Descriptor word to write |
| desc_rdata | output | 128 | Descriptor word at `desc_idx` (combinational) |
| rx_len | input | 12 | Received length, captured on completion (receive ring) |
| rx_eof | input | 4 | Received end-of-frame field |
| rx_sof | input | 4 | Received start-of-frame field |
| xfer_start | output | 1 | One-cycle launch of a descriptor's transfer |
| xfer_addr | output | 64 | Buffer address of the launched descriptor |
| xfer_len | output | 12 | Length of the launched descriptor |
| cmpl_pulse | output | 1 | Completion notification pulse |
| err_halt | output | 1 | Ring halted on an unposted descriptor |
| ring_busy | output | 1 | A transfer is in flight |

## Verification
The bench builds the block with `DEPTH` 16, `XFER_LAT` 3 and `IS_RX` 1. The receive write-back of length and frame fields is therefore observable in every completed descriptor. The 16-entry store lets the bench show that an over-range count write is clamped. It also lets small rings of 4 and 8 slots exercise the tail wrap. The three-cycle transfer gives the bench a window between a launch and its completion, which the mid-flight disable scenario needs.

// File: rtl/ring_pkg.sv
package ring_pkg;

   localparam int DESC_W = 128;

   typedef struct packed {
      logic [31:0] stamp;
      logic [11:0] flags;
      logic [3:0]  sof;
      logic [3:0]  eof;
      logic [11:0] len;
      logic [63:0] addr;
   } desc_t;

   localparam int FLG_ISOCH  = 0;
   localparam int FLG_DONE   = 1;
   localparam int FLG_POSTED = 2;
   localparam int FLG_IRQ    = 3;

   localparam int RF_ISOCH   = 27;
   localparam int RF_E2E     = 28;
   localparam int RF_NOSNOOP = 29;
   localparam int RF_RAW     = 30;
   localparam int RF_ENABLE  = 31;

   typedef enum logic [1:0] {
      RA_FLAGS = 2'd0,
      RA_COUNT = 2'd1,
      RA_HEAD  = 2'd2,
      RA_TAIL  = 2'd3
   } reg_addr_t;

endpackage

// File: rtl/desc_store.sv
module desc_store import ring_pkg::*; #(
   parameter int DEPTH = 16,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             sw_we,
   input  logic [IDX_W-1:0] sw_idx,
   input  desc_t            sw_data,
   input  logic             hw_we,
   input  logic [IDX_W-1:0] hw_idx,
   input  desc_t            hw_data,
   input  logic [IDX_W-1:0] hw_rd_idx,
   output desc_t            hw_rd,
   output desc_t            sw_rd
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("desc_store: DEPTH must be at least 2");
      end
   endgenerate

   desc_t mem [DEPTH];

   // engine write-back is placed last so it wins a same-slot collision
   always_ff @(posedge clk) begin
      if (sw_we) mem[sw_idx] <= sw_data;
      if (hw_we) mem[hw_idx] <= hw_data;
   end

   assign hw_rd = mem[hw_rd_idx];
   assign sw_rd = mem[sw_idx];

endmodule

// File: rtl/xfer_stub.sv
module xfer_stub #(
   parameter int LAT = 3,
   localparam int CW = $clog2(LAT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);

   generate
      if (LAT < 1) begin : g_bad_lat
         $error("xfer_stub: LAT must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (start)          cnt_q <= CW'(LAT);
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign busy = (cnt_q != '0);
   assign done = (cnt_q == CW'(1));

   AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);                                            // R3

endmodule

// File: rtl/ring_regs.sv
module ring_regs import ring_pkg::*; #(
   parameter int DEPTH = 16,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = IDX_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [1:0]       addr,
   input  logic [31:0]      wdata,
   input  logic [IDX_W-1:0] tail,
   output logic [31:0]      rdata,
   output logic             enable,
   output logic [CNT_W-1:0] count,
   output logic [IDX_W-1:0] head,
   output logic             cnt_wr,
   output logic             err_clr
);

   logic [31:0]      flags_q;
   logic [CNT_W-1:0] count_q;
   logic [IDX_W-1:0] head_q;
   logic [CNT_W-1:0] count_in;

   // clamp the requested size to the store depth
   always_comb begin
      if (wdata > 32'(DEPTH)) count_in = CNT_W'(DEPTH);
      else                    count_in = wdata[CNT_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags_q <= '0;
         count_q <= '0;
         head_q  <= '0;
      end else if (we) begin
         case (reg_addr_t'(addr))
            RA_FLAGS: flags_q <= wdata;
            RA_COUNT: count_q <= count_in;
            RA_HEAD:  head_q  <= wdata[IDX_W-1:0];
            default:  ;
         endcase
      end
   end

   assign cnt_wr  = we && (reg_addr_t'(addr) == RA_COUNT);
   assign err_clr = we && (reg_addr_t'(addr) == RA_FLAGS) && !wdata[RF_ENABLE];
   assign enable  = flags_q[RF_ENABLE];
   assign count   = count_q;
   assign head    = head_q;

   always_comb begin
      case (reg_addr_t'(addr))
         RA_FLAGS: rdata = flags_q;
         RA_COUNT: rdata = 32'(count_q);
         RA_HEAD:  rdata = 32'(head_q);
         default:  rdata = 32'(tail);
      endcase
   end

   AST_COUNT_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= CNT_W'(DEPTH));                                   // R4

endmodule

// File: rtl/ring_ctrl.sv
module ring_ctrl import ring_pkg::*; #(
   parameter int DEPTH = 16,
   parameter bit IS_RX = 1'b1,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = IDX_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [CNT_W-1:0] count,
   input  logic [IDX_W-1:0] head,
   input  logic             cnt_wr,
   input  logic             err_clr,
   input  desc_t            cur,
   input  logic             xdone,
   input  logic [11:0]      rx_len,
   input  logic [3:0]       rx_eof,
   input  logic [3:0]       rx_sof,
   output logic [IDX_W-1:0] tail,
   output logic             start,
   output logic             wb_we,
   output desc_t            wb_data,
   output logic             pulse,
   output logic             err,
   output logic             busy
);

   typedef enum logic {ST_IDLE, ST_RUN} st_t;

   st_t              st_q;
   logic [IDX_W-1:0] tail_q;
   logic [IDX_W-1:0] tail_nxt;
   logic             pulse_q;
   logic             err_q;
   logic             go;

   always_comb begin
      if (CNT_W'(tail_q) + 1'b1 == count) tail_nxt = '0;
      else                                tail_nxt = tail_q + 1'b1;
   end

   assign go    = (st_q == ST_IDLE) && enable && (count != '0) &&
                  (tail_q != head) && !err_q;
   assign start = go && cur.flags[FLG_POSTED];
   assign wb_we = (st_q == ST_RUN) && xdone;

   generate
      if (IS_RX) begin : g_rx_fill
         always_comb begin
            wb_data                 = cur;
            wb_data.flags[FLG_DONE] = 1'b1;
            wb_data.len             = rx_len;
            wb_data.eof             = rx_eof;
            wb_data.sof             = rx_sof;
         end
      end else begin : g_tx_keep
         always_comb begin
            wb_data                 = cur;
            wb_data.flags[FLG_DONE] = 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         tail_q  <= '0;
         pulse_q <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         pulse_q <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (start)   st_q  <= ST_RUN;
               else if (go) err_q <= 1'b1;
            end
            default: begin
               if (xdone) begin
                  st_q    <= ST_IDLE;
                  tail_q  <= tail_nxt;
                  pulse_q <= cur.flags[FLG_IRQ];
               end
            end
         endcase
         if (err_clr) err_q  <= 1'b0;
         if (cnt_wr)  tail_q <= '0;
      end
   end

   assign tail  = tail_q;
   assign pulse = pulse_q;
   assign err   = err_q;
   assign busy  = (st_q == ST_RUN);

   AST_TAIL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (count != '0) |-> (CNT_W'(tail_q) < count));                 // R4
   AST_TAIL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tail_q != $past(tail_q) && !$past(cnt_wr)) |->
      (tail_q == ((CNT_W'($past(tail_q)) + 1'b1 == $past(count)) ?
                  IDX_W'(0) : IDX_W'($past(tail_q) + 1'b1))));     // R3
   AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> enable);                                           // R5
   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |=> !pulse_q);                                       // R6
   AST_ERR_FREEZES_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && $past(err_q) && !$past(cnt_wr)) |->
      (tail_q == $past(tail_q)));                                  // R7
   AST_ERR_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> !start);                                           // R7

endmodule

// File: rtl/ring_walker.sv
module ring_walker import ring_pkg::*; #(
   parameter int DEPTH    = 16,
   parameter int XFER_LAT = 3,
   parameter bit IS_RX    = 1'b1,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = IDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [1:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              desc_we,
   input  logic [IDX_W-1:0]  desc_idx,
   input  logic [DESC_W-1:0] desc_wdata,
   output logic [DESC_W-1:0] desc_rdata,
   input  logic [11:0]       rx_len,
   input  logic [3:0]        rx_eof,
   input  logic [3:0]        rx_sof,
   output logic              xfer_start,
   output logic [63:0]       xfer_addr,
   output logic [11:0]       xfer_len,
   output logic              cmpl_pulse,
   output logic              err_halt,
   output logic              ring_busy
);

   logic             enable;
   logic [CNT_W-1:0] count;
   logic [IDX_W-1:0] head;
   logic [IDX_W-1:0] tail;
   logic             cnt_wr;
   logic             err_clr;
   logic             start;
   logic             xbusy;
   logic             xdone;
   logic             wb_we;
   desc_t            wb_data;
   desc_t            cur;
   desc_t            sw_rd;

   ring_regs #(.DEPTH(DEPTH)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (reg_we),
      .addr    (reg_addr),
      .wdata   (reg_wdata),
      .tail    (tail),
      .rdata   (reg_rdata),
      .enable  (enable),
      .count   (count),
      .head    (head),
      .cnt_wr  (cnt_wr),
      .err_clr (err_clr)
   );

   desc_store #(.DEPTH(DEPTH)) u_store (
      .clk       (clk),
      .sw_we     (desc_we),
      .sw_idx    (desc_idx),
      .sw_data   (desc_t'(desc_wdata)),
      .hw_we     (wb_we),
      .hw_idx    (tail),
      .hw_data   (wb_data),
      .hw_rd_idx (tail),
      .hw_rd     (cur),
      .sw_rd     (sw_rd)
   );

   xfer_stub #(.LAT(XFER_LAT)) u_stub (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .busy  (xbusy),
      .done  (xdone)
   );

   ring_ctrl #(.DEPTH(DEPTH), .IS_RX(IS_RX)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (enable),
      .count   (count),
      .head    (head),
      .cnt_wr  (cnt_wr),
      .err_clr (err_clr),
      .cur     (cur),
      .xdone   (xdone),
      .rx_len  (rx_len),
      .rx_eof  (rx_eof),
      .rx_sof  (rx_sof),
      .tail    (tail),
      .start   (start),
      .wb_we   (wb_we),
      .wb_data (wb_data),
      .pulse   (cmpl_pulse),
      .err     (err_halt),
      .busy    (ring_busy)
   );

   assign desc_rdata = sw_rd;
   assign xfer_start = start;
   assign xfer_addr  = cur.addr;
   assign xfer_len   = cur.len;

   AST_BUSY_MATCHES_STUB: assert property (@(posedge clk) disable iff (!rst_n)
      ring_busy == xbusy);                                         // R3
   AST_WB_UNPOSTED: assert property (@(posedge clk) disable iff (!rst_n)
      wb_we |-> cur.flags[FLG_POSTED]);                            // R7

endmodule

// File: tb/ring_walker_bench.sv
module ring_walker_bench;
   import ring_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 16;
   localparam int IDX_W = $clog2(DEPTH);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_we = 1'b0;
   logic [1:0]        reg_addr = '0;
   logic [31:0]       reg_wdata = '0;
   logic [31:0]       reg_rdata;
   logic              desc_we = 1'b0;
   logic [IDX_W-1:0]  desc_idx = '0;
   logic [DESC_W-1:0] desc_wdata = '0;
   logic [DESC_W-1:0] desc_rdata;
   logic [11:0]       rx_len = 12'h123;
   logic [3:0]        rx_eof = 4'h5;
   logic [3:0]        rx_sof = 4'h9;
   logic              xfer_start;
   logic [63:0]       xfer_addr;
   logic [11:0]       xfer_len;
   logic              cmpl_pulse;
   logic              err_halt;
   logic              ring_busy;

   int n_chk = 0;
   int n_bad = 0;
   int n_pulse = 0;
   int n_start = 0;
   logic [63:0] start_log [64];

   always #(CLK_PERIOD/2) clk = ~clk;

   ring_walker #(.DEPTH(DEPTH), .XFER_LAT(3), .IS_RX(1'b1)) u_ring_walker (
      .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
      .desc_we, .desc_idx, .desc_wdata, .desc_rdata,
      .rx_len, .rx_eof, .rx_sof,
      .xfer_start, .xfer_addr, .xfer_len,
      .cmpl_pulse, .err_halt, .ring_busy
   );

   always @(negedge clk) begin
      if (rst_n && cmpl_pulse) n_pulse++;
      if (rst_n && xfer_start) begin
         if (n_start < 64) start_log[n_start] = xfer_addr;
         n_start++;
      end
   end

   task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
      reg_addr = a; #1; d = reg_rdata;
   endtask

   task automatic wr_desc(input int i, input desc_t d);
      desc_idx = IDX_W'(i); desc_wdata = d; desc_we = 1'b1;
      @(negedge clk);
      desc_we = 1'b0;
   endtask

   task automatic rd_desc(input int i, output desc_t d);
      desc_idx = IDX_W'(i); #1; d = desc_t'(desc_rdata);
   endtask

   function automatic desc_t mk(input int i, input bit posted, input bit irq);
      desc_t d;
      d.addr  = 64'hA000_0000_0000_0000 + 64'(i) * 64'h40;
      d.len   = 12'h040 + 12'(i);
      d.eof   = 4'h1;
      d.sof   = 4'h2;
      d.flags = '0;
      d.flags[FLG_POSTED] = posted;
      d.flags[FLG_IRQ]    = irq;
      d.stamp = '0;
      return d;
   endfunction

   task automatic wait_tail(input int exp, input string tag);
      logic [31:0] t;
      for (int k = 0; k < 200; k++) begin
         rd_reg(RA_TAIL, t);
         if (t == 32'(exp)) break;
         @(negedge clk);
      end
      repeat (3) @(negedge clk);
      rd_reg(RA_TAIL, t);
      chk(tag, t, exp);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd_reg(RA_FLAGS, v); chk("R1 flags", v, 0);
      rd_reg(RA_COUNT, v); chk("R1 count", v, 0);
      rd_reg(RA_HEAD,  v); chk("R1 head",  v, 0);
      rd_reg(RA_TAIL,  v); chk("R1 tail",  v, 0);
      chk("R1 outputs", {err_halt, cmpl_pulse, ring_busy, xfer_start}, 0);
   endtask

   task automatic t_basic();
      desc_t d, e;
      int p0, s0;
      logic [31:0] v;
      wr_reg(RA_COUNT, 8);
      for (int i = 0; i < 4; i++) wr_desc(i, mk(i, 1'b1, (i % 2) == 0));
      p0 = n_pulse; s0 = n_start;
      wr_reg(RA_FLAGS, 32'h8000_0000);
      wr_reg(RA_HEAD, 4);
      wait_tail(4, "R3 tail reaches head");
      repeat (20) @(negedge clk);
      rd_reg(RA_TAIL, v); chk("R3 tail holds at head", v, 4);
      chk("R3 one start per descriptor", n_start - s0, 4);
      for (int i = 0; i < 4; i++)
         chk("R3 launch order", start_log[s0 + i], mk(i, 1'b1, 1'b0).addr);
      chk("R6 pulses for irq descriptors", n_pulse - p0, 2);
      for (int i = 0; i < 4; i++) begin
         rd_desc(i, d);
         e = mk(i, 1'b1, (i % 2) == 0);
         e.flags[FLG_DONE] = 1'b1;
         e.len = 12'h123; e.eof = 4'h5; e.sof = 4'h9;
         chk("R2 R8 written-back descriptor", d, e);
      end
      chk("R3 idle after ring drained", ring_busy, 0);
   endtask

   task automatic t_wrap();
      desc_t d;
      int p0, s0;
      logic [31:0] v;
      wr_reg(RA_FLAGS, 0);
      wr_reg(RA_COUNT, 100);
      rd_reg(RA_COUNT, v); chk("R4 count clamped to depth", v, DEPTH);
      wr_reg(RA_COUNT, 4);
      rd_reg(RA_TAIL, v); chk("R4 count write resets tail", v, 0);
      for (int i = 0; i < 4; i++) wr_desc(i, mk(i, 1'b1, 1'b0));
      wr_reg(RA_HEAD, 3);
      p0 = n_pulse;
      wr_reg(RA_FLAGS, 32'h8000_0000);
      wait_tail(3, "R4 tail before wrap");
      s0 = n_start;
      wr_reg(RA_HEAD, 1);
      wait_tail(1, "R4 tail after wrap");
      chk("R4 wrap launch slot 3", start_log[s0],     mk(3, 1'b1, 1'b0).addr);
      chk("R4 wrap launch slot 0", start_log[s0 + 1], mk(0, 1'b1, 1'b0).addr);
      rd_desc(3, d); chk("R4 slot 3 completed", d.flags[FLG_DONE], 1);
      chk("R6 no pulse without irq", n_pulse - p0, 0);
   endtask

   task automatic t_disable();
      desc_t d;
      int s0;
      logic [31:0] v;
      wr_reg(RA_FLAGS, 0);
      wr_reg(RA_COUNT, 8);
      for (int i = 0; i < 6; i++) wr_desc(i, mk(i, 1'b1, 1'b0));
      wr_reg(RA_HEAD, 5);
      s0 = n_start;
      reg_addr = RA_FLAGS; reg_wdata = 32'h8000_0000; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
      for (int k = 0; k < 50 && !xfer_start; k++) @(negedge clk);
      wr_reg(RA_FLAGS, 0);
      repeat (30) @(negedge clk);
      rd_reg(RA_TAIL, v); chk("R5 in-flight descriptor finishes", v, 1);
      chk("R5 no launch after disable", n_start - s0, 1);
      rd_desc(1, d); chk("R5 next descriptor untouched", d.flags[FLG_DONE], 0);
      wr_reg(RA_FLAGS, 32'h8000_0000);
      wait_tail(5, "R5 resumes on re-enable");
   endtask

   task automatic t_error();
      desc_t d;
      int s0;
      logic [31:0] v;
      wr_reg(RA_FLAGS, 0);
      wr_reg(RA_COUNT, 4);
      wr_desc(0, mk(0, 1'b1, 1'b0));
      wr_desc(1, mk(1, 1'b0, 1'b1));
      wr_desc(2, mk(2, 1'b1, 1'b0));
      wr_reg(RA_HEAD, 3);
      s0 = n_start;
      wr_reg(RA_FLAGS, 32'h8000_0000);
      repeat (30) @(negedge clk);
      rd_reg(RA_TAIL, v); chk("R7 tail stops at unposted slot", v, 1);
      chk("R7 error raised", err_halt, 1);
      chk("R7 only one launch", n_start - s0, 1);
      rd_desc(1, d); chk("R7 unposted slot unchanged", d, mk(1, 1'b0, 1'b1));
      wr_reg(RA_FLAGS, 0);
      chk("R7 error cleared by disable write", err_halt, 0);
      wr_desc(1, mk(1, 1'b1, 1'b0));
      wr_reg(RA_FLAGS, 32'h8000_0000);
      wait_tail(3, "R7 ring resumes after clear");
      chk("R7 no error after resume", err_halt, 0);
   endtask

   task automatic t_tail_ro();
      logic [31:0] v;
      wr_reg(RA_FLAGS, 0);
      wr_reg(RA_TAIL, 2);
      @(negedge clk);
      rd_reg(RA_TAIL, v); chk("R9 tail write ignored", v, 3);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_wrap();
      t_disable();
      t_error();
      t_tail_ro();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule